// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a cycle-level model of a byte-wide nonvolatile memory that sits on a two-wire serial bus as a target. It runs on a fast system clock and watches oversampled copies of the bus clock and data lines. Its only bus output is an enable for an open-drain pull-down on the data line. A controller selects the block with a device word. The upper nibble of that word is the fixed pattern 1010. The next three bits must equal the three strap inputs, and the last bit picks read (1) or write (0). Writes set a word address and then load up to a page of bytes. Those bytes are programmed into the array only after the controller ends the transfer with a stop. Reads return bytes from the current address for as long as the controller acknowledges them.

The array holds 2^ADDR_W bytes in pages of 2^PAGE_W bytes. The full-size configuration is ADDR_W = 13 with 32-byte pages, which gives 8192 bytes reached at word addresses 0x0000 to 0x1FFF. The default elaboration uses ADDR_W = 11 to keep the memory small. A write-cycle counter of WR_CYCLES system clocks stands for the programming time. While it runs, the block ignores its own device word, so a controller can poll for completion. The write-protect input, when high, shields the top quarter of the array: the addresses whose two most significant bits are both 1.

The controller is a single state machine. Any start condition moves it to DEV_WORD, and any stop moves it to IDLE. The transitions are:

- DEV_WORD, after 8 bits, goes to DEV_ACK on a match while not busy, and to IDLE otherwise.
- DEV_ACK goes to READ_BYTE for a read and to ADDR_HI for a write.
- ADDR_HI goes to ADDR_HI_ACK, then ADDR_LO, then ADDR_LO_ACK, then WR_BYTE.
- WR_BYTE and WR_BYTE_ACK alternate for each data byte.
- READ_BYTE goes to READ_ACK after 8 bits.
- READ_ACK returns to READ_BYTE when the controller acknowledges, and goes to IDLE on a no-acknowledge.

Each ACK state leaves on the second falling SCL edge it sees. The first falling edge turns the pull-down on, and the second ends the ninth clock.

Top module: `twi_eeprom_target`

## Requirements
- R1: A start (SDA falls while SCL is high) in any state begins a new device word. A stop (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: The block acknowledges a device word only when its bits 7:4 are 1010 and bits 3:1 equal strap_i. Bit 0 is 1 for read and 0 for write. Any other device word is not acknowledged, and the block ignores the bus until the next start.
- R3: Bytes are received MSB first, sampled on rising SCL. Each accepted byte is acknowledged by pulling SDA low for the whole ninth clock. The SDA enable changes only while SCL is low.
- R4: The word address is two bytes, high byte first. Only the low ADDR_W bits of {high, low} are used, and the higher bits of the high byte are ignored.
- R5: During a write, each data byte goes to the current address. Then only the low PAGE_W address bits advance, wrapping within the page, so later bytes overwrite earlier ones. Bytes reach the array only when a stop ends the sequence; a new start before the stop discards them.
- R6: The write cycle starts at the stop that ends a write sequence and lasts WR_CYCLES system clocks. The array changes only during it.
- R7: While the write cycle runs, the block does not acknowledge its device word.
- R8: With wp_i high at the closing stop, bytes aimed at addresses whose two top bits are 11 are not written, and the other bytes in the page are. With wp_i low, every byte is written.
- R9: A write of the word address, a repeated start and a read device word return the byte at that address.
- R10: A read continues while the controller acknowledges each byte. The address advances across the whole array, wrapping from the last address to 0. A no-acknowledge ends the read and releases SDA.
- R11: A read with no address phase starts at the address following the last byte read or written.
- R12: After reset SDA is released, the block is idle and no write cycle runs, so the first device word is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wired-AND) |
| strap_i | input | 3 | Hard-wired device select bits |
| wp_i | input | 1 | Write protect for the top quarter of the array |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
The bench sweeps all 128 seven-bit device words. A wrong prefix or strap compare would then show up as a stray or missing acknowledge. A page write of 36 bytes starting two bytes before the page end targets the wrap: a design that carried into the row bits would corrupt the next page, and one that did not wrap would lose the overwrites. A sequential read across the top of the array checks that the read address wraps to 0. A repeated start in mid-write checks that uncommitted bytes are discarded, since committing them would alter the array and make the block busy. Polling straight after a stop must see no acknowledge. Protected and unprotected bytes written under wp_i must split exactly at the quarter boundary. High address bytes with junk in the unused bits must land at the truncated address.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV_WORD,
        S_DEV_ACK,
        S_ADDR_HI,
        S_ADDR_HI_ACK,
        S_ADDR_LO,
        S_ADDR_LO_ACK,
        S_WR_BYTE,
        S_WR_BYTE_ACK,
        S_READ_BYTE,
        S_READ_ACK
    } tgt_state_e;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sh[SYNC_STAGES-1];
            sda_prev <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_o      = scl_sh[SYNC_STAGES-1];
    assign sda_o      = sda_sh[SYNC_STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/twi_commit_timer.sv
module twi_commit_timer #(
    parameter int WR_CYCLES = 1250000,
    parameter int PAGE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              busy_o,
    output logic              slot_vld_o,
    output logic [PAGE_W-1:0] slot_o
);

    localparam int CNT_W      = $clog2(WR_CYCLES + 1);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (go_i && remain == '0) begin
            remain <= CNT_W'(WR_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy_o     = (remain != '0);
    assign elapsed    = CNT_W'(WR_CYCLES) - remain;
    assign slot_vld_o = busy_o && (elapsed < CNT_W'(PAGE_BYTES));
    assign slot_o     = elapsed[PAGE_W-1:0];

    // independent length counter used only to check the busy window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (go_i) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end
    end

    p_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == CNT_W'(WR_CYCLES)));

endmodule

// File: rtl/twi_eeprom_array.sv
module twi_eeprom_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int WR_CYCLES   = 1250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;

    tgt_state_e state, state_nx;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
    logic [2:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        byte_in;
    logic              ack_on;
    logic              rw;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] new_addr;
    logic [7:0]        addr_hi;
    logic [7:0]        pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic              wr_pend;
    logic              wp_lat;
    logic [ROW_W-1:0]  row_lat;
    logic              commit_go;
    logic              oe;
    logic              dev_match;
    logic              byte_end;

    logic              wr_busy, slot_vld;
    logic [PAGE_W-1:0] slot;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [7:0]        rdata;

    twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_s),
        .stop_o     (stop_s)
    );

    twi_commit_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (commit_go),
        .busy_o     (wr_busy),
        .slot_vld_o (slot_vld),
        .slot_o     (slot)
    );

    assign mem_wa = {row_lat, slot};
    assign mem_we = slot_vld && pvalid[slot] && !(wp_lat && (&mem_wa[ADDR_W-1 -: 2]));

    twi_eeprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_wa),
        .wdata_i (pbuf[slot]),
        .raddr_i (addr),
        .rdata_o (rdata)
    );

    assign byte_in   = {shreg[6:0], sda_s};
    assign new_addr  = ADDR_W'({addr_hi, byte_in});
    assign dev_match = (byte_in[7:4] == DEV_PREFIX) && (byte_in[3:1] == strap_i);
    assign byte_end  = scl_rise && (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_s) begin
            state_nx = S_DEV_WORD;
        end else if (stop_s) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:        state_nx = S_IDLE;
                S_DEV_WORD:    if (byte_end) state_nx = (dev_match && !wr_busy) ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:     if (scl_fall && ack_on) state_nx = rw ? S_READ_BYTE : S_ADDR_HI;
                S_ADDR_HI:     if (byte_end) state_nx = S_ADDR_HI_ACK;
                S_ADDR_HI_ACK: if (scl_fall && ack_on) state_nx = S_ADDR_LO;
                S_ADDR_LO:     if (byte_end) state_nx = S_ADDR_LO_ACK;
                S_ADDR_LO_ACK: if (scl_fall && ack_on) state_nx = S_WR_BYTE;
                S_WR_BYTE:     if (byte_end) state_nx = S_WR_BYTE_ACK;
                S_WR_BYTE_ACK: if (scl_fall && ack_on) state_nx = S_WR_BYTE;
                S_READ_BYTE:   if (scl_fall && bit_cnt == 3'd7) state_nx = S_READ_ACK;
                S_READ_ACK: begin
                    if (scl_rise && sda_s)      state_nx = S_IDLE;
                    else if (scl_fall && ack_on) state_nx = S_READ_BYTE;
                end
                default:       state_nx = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_on    <= 1'b0;
            oe        <= 1'b0;
            rw        <= 1'b0;
            addr      <= '0;
            addr_hi   <= '0;
            pvalid    <= '0;
            wr_pend   <= 1'b0;
            wp_lat    <= 1'b0;
            row_lat   <= '0;
            commit_go <= 1'b0;
        end else begin
            commit_go <= 1'b0;
            if (start_s) begin
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                oe      <= 1'b0;
                wr_pend <= 1'b0;
            end else if (stop_s) begin
                bit_cnt <= '0;
                ack_on  <= 1'b0;
                oe      <= 1'b0;
                if (wr_pend) begin
                    commit_go <= 1'b1;
                    wr_pend   <= 1'b0;
                    wp_lat    <= wp_i;
                end
            end else begin
                case (state)
                    S_DEV_WORD, S_ADDR_HI, S_ADDR_LO, S_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg   <= byte_in;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                ack_on <= 1'b0;
                                if (state == S_DEV_WORD) rw <= sda_s;
                                if (state == S_ADDR_HI)  addr_hi <= byte_in;
                                if (state == S_ADDR_LO) begin
                                    addr    <= new_addr;
                                    row_lat <= new_addr[ADDR_W-1:PAGE_W];
                                    pvalid  <= '0;
                                end
                                if (state == S_WR_BYTE) begin
                                    pbuf[addr[PAGE_W-1:0]]   <= byte_in;
                                    pvalid[addr[PAGE_W-1:0]] <= 1'b1;
                                    wr_pend                  <= 1'b1;
                                    addr[PAGE_W-1:0]         <= addr[PAGE_W-1:0] + 1'b1;
                                end
                            end
                        end
                    end
                    S_DEV_ACK, S_ADDR_HI_ACK, S_ADDR_LO_ACK, S_WR_BYTE_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                ack_on <= 1'b1;
                                oe     <= 1'b1;
                            end else begin
                                ack_on  <= 1'b0;
                                bit_cnt <= '0;
                                if (state == S_DEV_ACK && rw) begin
                                    shreg <= rdata;
                                    oe    <= ~rdata[7];
                                end else begin
                                    oe <= 1'b0;
                                end
                            end
                        end
                    end
                    S_READ_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                oe      <= 1'b0;
                                bit_cnt <= '0;
                                ack_on  <= 1'b0;
                                addr    <= addr + 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                                oe      <= ~shreg[6];
                                shreg   <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    S_READ_ACK: begin
                        if (scl_rise && !sda_s) ack_on <= 1'b1;
                        if (scl_fall && ack_on) begin
                            ack_on <= 1'b0;
                            shreg  <= rdata;
                            oe     <= ~rdata[7];
                        end
                    end
                    default: oe <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe_o = oe;

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe_o);

    p_oe_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

    p_page_row_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_BYTE_ACK) |-> $stable(addr[ADDR_W-1:PAGE_W]));

    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(stop_s, 2));

    p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV_ACK && sda_oe_o) |-> !wr_busy);

endmodule

// File: tb/twi_eeprom_target_test.sv
module twi_eeprom_target_test;

    localparam int AW   = 9;
    localparam int PW   = 5;
    localparam int WRC  = 400;
    localparam int Q    = 8;
    localparam int SIZE = 1 << AW;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] model [SIZE];
    logic [7:0] wbuf [64];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, STRAP, rd};
    endfunction

    task automatic wait_ready();
        logic a;
        for (int k = 0; k < 40; k++) begin
            bus_start();
            send_byte(dev(1'b0), a);
            bus_stop();
            if (a) return;
            tick(40);
        end
        check(1'b0, "R6 write cycle never ended", 0, 1);
    endtask

    task automatic set_addr(input logic [15:0] a16);
        logic a;
        bus_start();
        send_byte(dev(1'b0), a);  check(a, "R2 device word ack", a, 1);
        send_byte(a16[15:8], a);  check(a, "R4 high address ack", a, 1);
        send_byte(a16[7:0], a);   check(a, "R4 low address ack", a, 1);
    endtask

    // write n bytes from wbuf; update the model using page wrap and protection
    task automatic write_seq(input logic [15:0] a16, input int n);
        logic a;
        logic [AW-1:0] eff;
        logic [AW-1:0] t;
        set_addr(a16);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            check(a, "R3 data byte ack", a, 1);
        end
        bus_stop();
        eff = a16[AW-1:0];
        for (int i = 0; i < n; i++) begin
            t = {eff[AW-1:PW], PW'(int'(eff[PW-1:0]) + i)};
            if (!(wp && t[AW-1:AW-2] == 2'b11)) model[t] = wbuf[i];
        end
    endtask

    task automatic read_seq(input int start_a, input int n, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(dev(1'b1), a);
        check(a, "R2 read device word ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check(v == model[(start_a + i) % SIZE], tag, v, model[(start_a + i) % SIZE]);
        end
        bus_stop();
        tick(4);
        check(sda_oe == 1'b0, "R10 bus released after no-ack and stop", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R12: reset state
        check(sda_oe == 1'b0, "R12 SDA released after reset", sda_oe, 0);
        bus_start();
        send_byte(dev(1'b0), a);
        check(a, "R12 first device word acked", a, 1);
        bus_stop();

        // R2: sweep every seven-bit device word with the write bit
        for (int w = 0; w < 128; w++) begin
            bus_start();
            send_byte({w[6:0], 1'b0}, a);
            check(a == (w[6:0] == {4'b1010, STRAP}), "R2 device word compare", a, w);
            bus_stop();
        end

        // R6, R7: byte write, busy poll, then ready
        wbuf[0] = 8'h5A;
        write_seq(16'h0003, 1);
        bus_start();
        send_byte(dev(1'b0), a);
        check(!a, "R7 no ack while write cycle busy", a, 0);
        bus_stop();
        tick(WRC);
        bus_start();
        send_byte(dev(1'b0), a);
        check(a, "R6 ack after write cycle", a, 1);
        bus_stop();
        set_addr(16'h0003);
        read_seq(3, 1, "R9 random read of byte write");

        // R5: page write of 36 bytes from offset 30 of row 2, row 3 guard
        wbuf[0] = 8'hC3;
        write_seq(16'h0060, 1);
        wait_ready();
        for (int i = 0; i < 36; i++) wbuf[i] = 8'(i * 7 + 3);
        write_seq(16'h005E, 36);
        wait_ready();
        set_addr(16'h0040);
        read_seq(16'h40, 33, "R5 page wrap contents");

        // R5: repeated start before stop discards the data
        wbuf[0] = 8'h11;
        write_seq(16'h0010, 1);
        wait_ready();
        set_addr(16'h0010);
        send_byte(8'h99, a);
        set_addr(16'h0010);
        read_seq(16'h10, 1, "R5 uncommitted byte discarded");

        // R10, R11: sequential read across the array end, then current address
        for (int i = 0; i < 2; i++) wbuf[i] = 8'hE0 + 8'(i);
        write_seq(16'h01FE, 2);
        wait_ready();
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h20 + 8'(i);
        write_seq(16'h0000, 4);
        wait_ready();
        set_addr(16'h01FE);
        read_seq(16'h1FE, 4, "R10 sequential read wraps at array end");
        read_seq(2, 1, "R11 current address read");

        // R8: write protect splits at the quarter boundary
        for (int i = 0; i < 2; i++) wbuf[i] = 8'h70 + 8'(i);
        write_seq(16'h0180, 2);
        wait_ready();
        wp = 1'b1;
        for (int i = 0; i < 2; i++) wbuf[i] = 8'hA0 + 8'(i);
        write_seq(16'h017E, 2);
        wait_ready();
        for (int i = 0; i < 2; i++) wbuf[i] = 8'hB0 + 8'(i);
        write_seq(16'h0180, 2);
        wait_ready();
        wp = 1'b0;
        set_addr(16'h017E);
        read_seq(16'h17E, 4, "R8 write protect boundary");

        // R4: unused high address bits ignored, used bit honoured
        wbuf[0] = 8'h3C;
        write_seq(16'hFE20, 1);
        wait_ready();
        wbuf[0] = 8'h4D;
        write_seq(16'hA130, 1);
        wait_ready();
        set_addr(16'h0020);
        read_seq(16'h020, 1, "R4 high byte truncation low half");
        set_addr(16'h0130);
        read_seq(16'h130, 1, "R4 high byte truncation upper half");

        // R1: start in mid-read aborts and a new device word is taken
        set_addr(16'h0000);
        bus_start();
        send_byte(dev(1'b1), a);
        recv_byte(1'b1, v);
        check(v == model[0], "R1 read before restart", v, model[0]);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            if (i == 5) break;
        end
        sda_m = 1'b1;
        while (sda_line == 1'b0) begin
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        bus_start();
        send_byte(dev(1'b0), a);
        check(a, "R1 start from mid-read restarts device word", a, 1);
        bus_stop();
        tick(4);
        check(sda_oe == 1'b0, "R1 stop releases SDA", sda_oe, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule